// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block collects up to seven interrupt sources into one active-high request line. Each source has a sticky pending flag and a matching enable bit. A source raises its flag with a one-cycle set pulse. The flag stays set until software clears it, or until a side-effect access elsewhere in the peripheral pulses the matching clear input. Flags are recorded whether or not the source is enabled, so software can poll them with the request line masked.

Software reaches the block through a byte-wide register port with two live offsets, one for flags and one for enables.

- **Flag register.** Writing it clears every flag whose bit is 1 in the low seven bits of the data. Its top bit is a summary and is never stored: it reads 1 when any flag is both pending and enabled.
- **Enable register.** The top bit of a write selects the operation. A 1 sets the marked enables and a 0 clears them. Its top bit always reads back as 1.
- **Request line.** The output is a flop that always agrees with the flag register's summary bit.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all seven flags and all seven enables are 0, `irq` is 0, a read at offset 13 returns 0x00 and a read at offset 14 returns 0x80.
- R2: A 1 on `src_set[i]` makes flag bit i read as 1 from the next cycle on, whatever the enable bit i holds.
- R3: A write at offset 13 clears every flag whose bit is 1 in `wr_data[6:0]`. `wr_data[7]` has no effect, and flags at 0 bits are untouched.
- R4: A 1 on `src_clr[i]` clears flag bit i in the next cycle.
- R5: When a set and a clear of the same flag (from `src_clr` or from a write at offset 13) fall in the same cycle, the flag ends up set.
- R6: A write at offset 14 with `wr_data[7]` = 0 clears the enables marked by ones in `wr_data[6:0]` and leaves the others unchanged.
- R7: A write at offset 14 with `wr_data[7]` = 1 sets the enables marked by ones in `wr_data[6:0]` and leaves the others unchanged.
- R8: A read at offset 14 returns the seven enables in bits 6..0 with bit 7 always 1.
- R9: A read at offset 13 returns the flags in bits 6..0. Bit 7 is 1 exactly when the AND of flags and enables is nonzero, and it follows every change to either register.
- R10: `irq` is a register output. In every cycle it equals the bit 7 that a read at offset 13 would return.
- R11: Timer one drives set input 6 and timer two drives set input 5. They appear at flag bits 6 and 5.
- R12: Writes at any offset other than 13 and 14 change neither register. Reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 4 | Register offset for reads and writes |
| wr_en | input | 1 | Write strobe for the selected offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected offset (combinational) |
| src_set | input | 7 | Per-source flag set pulses |
| src_clr | input | 7 | Per-source flag clear pulses from side-effect accesses |
| irq | output | 1 | Registered active-high interrupt request |

## Verification
The two functions that can collide are a source raising its flag and a clear of that same flag. The clear may come from the side-effect input or from a write at the flag offset. Directed cycles drive both on one bit at once, with the request enabled and then masked. A pseudo-random stretch overlaps set, clear and enable traffic freely. A behavioural model in the bench judges each cycle. It applies set after clear and compares the read data and `irq` on every clock, so a lost set shows up as a cleared flag bit and a dropped summary bit one cycle later.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
   typedef enum logic {
      ENA_CLEAR = 1'b0,
      ENA_SET   = 1'b1
   } ena_op_e;

   localparam int TMR1_SRC = 6;
   localparam int TMR2_SRC = 5;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int NSRC = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] flag_o,
   output logic [NSRC-1:0] flag_nxt_o
);
   initial assert (NSRC >= 1) else $error("NSRC must be at least 1");

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      logic q;
      logic nxt;
      always_comb nxt = set_i[i] | (q & ~clr_i[i]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= nxt;
      end
      assign flag_o[i]     = q;
      assign flag_nxt_o[i] = nxt;
   end

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((flag_o & $past(set_i)) == $past(set_i))); // R5
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((flag_o & $past(clr_i & ~set_i)) == '0)); // R4
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(flag_o)); // R12
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
   import irq_regs_pkg::*;
#(
   parameter int NSRC = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  ena_op_e         op_i,
   input  logic [NSRC-1:0] mask_i,
   output logic [NSRC-1:0] ena_o,
   output logic [NSRC-1:0] ena_nxt_o
);
   logic [NSRC-1:0] ena_q;

   always_comb begin
      ena_nxt_o = ena_q;
      if (wr_i) begin
         if (op_i == ENA_SET) ena_nxt_o = ena_q | mask_i;
         else                 ena_nxt_o = ena_q & ~mask_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ena_q <= '0;
      else        ena_q <= ena_nxt_o;
   end

   assign ena_o = ena_q;

   AST_ENA_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && op_i == ENA_SET) |=> ((ena_o & $past(mask_i)) == $past(mask_i))); // R7
   AST_ENA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && op_i == ENA_CLEAR) |=> ((ena_o & $past(mask_i)) == '0)); // R6
   AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(ena_o)); // R12
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
   parameter int NSRC = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] flag_nxt_i,
   input  logic [NSRC-1:0] ena_nxt_i,
   output logic            irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(flag_nxt_i & ena_nxt_i);
   end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irq_regs_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 4,
   parameter int FLAG_OFS = 13,
   parameter int ENA_OFS  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-2:0] src_set,
   input  logic [DATA_W-2:0] src_clr,
   output logic              irq
);
   localparam int NSRC = DATA_W - 1;
   localparam logic [ADDR_W-1:0] FLAG_SEL = ADDR_W'(FLAG_OFS);
   localparam logic [ADDR_W-1:0] ENA_SEL  = ADDR_W'(ENA_OFS);

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W too small");
      assert (FLAG_OFS != ENA_OFS) else $error("offsets collide");
      assert (FLAG_OFS < (1 << ADDR_W) && ENA_OFS < (1 << ADDR_W))
         else $error("offset outside address range");
      assert (TMR1_SRC < NSRC && TMR2_SRC < NSRC) else $error("timer source out of range");
   end

   logic            hit_flag_wr;
   logic            hit_ena_wr;
   logic [NSRC-1:0] sw_clr;
   logic [NSRC-1:0] flag_q;
   logic [NSRC-1:0] flag_nxt;
   logic [NSRC-1:0] ena_q;
   logic [NSRC-1:0] ena_nxt;
   logic            pending;
   ena_op_e         ena_op;

   assign hit_flag_wr = wr_en && (reg_sel == FLAG_SEL);
   assign hit_ena_wr  = wr_en && (reg_sel == ENA_SEL);
   assign sw_clr      = hit_flag_wr ? wr_data[NSRC-1:0] : '0;
   assign ena_op      = ena_op_e'(wr_data[DATA_W-1]);

   irq_flag_bank #(.NSRC(NSRC)) i_flags (
      .clk(clk), .rst_n(rst_n),
      .set_i(src_set), .clr_i(sw_clr | src_clr),
      .flag_o(flag_q), .flag_nxt_o(flag_nxt)
   );

   irq_enable_bank #(.NSRC(NSRC)) i_enables (
      .clk(clk), .rst_n(rst_n),
      .wr_i(hit_ena_wr), .op_i(ena_op), .mask_i(wr_data[NSRC-1:0]),
      .ena_o(ena_q), .ena_nxt_o(ena_nxt)
   );

   irq_summary #(.NSRC(NSRC)) i_summary (
      .clk(clk), .rst_n(rst_n),
      .flag_nxt_i(flag_nxt), .ena_nxt_i(ena_nxt),
      .irq_o(irq)
   );

   assign pending = |(flag_q & ena_q);

   always_comb begin
      if (reg_sel == FLAG_SEL)     rd_data = {pending, flag_q};
      else if (reg_sel == ENA_SEL) rd_data = {1'b1, ena_q};
      else                         rd_data = '0;
   end

   AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(flag_q & ena_q)); // R10
   AST_W1C_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_flag_wr && src_set == '0) |=> ((flag_q & $past(wr_data[NSRC-1:0])) == '0)); // R3
   AST_POLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (src_set != '0 && ena_q == '0 && !hit_ena_wr) |=> (flag_q != '0 && !irq)); // R2
endmodule

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_sel = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [6:0] src_set = '0;
   logic [6:0] src_clr = '0;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [6:0] m_f = '0;
   logic [6:0] m_e = '0;

   always #2 clk = ~clk;

   irq_flag_ctrl i_irq_flag_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .src_set(src_set),
      .src_clr(src_clr), .irq(irq)
   );

   function automatic logic [7:0] exp_rd(logic [3:0] s);
      if (s == 4'd13) return {|(m_f & m_e), m_f};
      if (s == 4'd14) return {1'b1, m_e};
      return 8'h00;
   endfunction

   task automatic chk(string r, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %02h expected %02h", r, what, act, exp);
      end
   endtask

   task automatic cyc(logic [6:0] s_set, logic [6:0] s_clr, logic w,
                      logic [3:0] s, logic [7:0] d, string r);
      logic [6:0] wclr;
      src_set = s_set; src_clr = s_clr; wr_en = w; reg_sel = s; wr_data = d;
      #1;
      chk(r, "read", rd_data, exp_rd(s));
      chk("R10", "irq", {7'b0, irq}, {7'b0, |(m_f & m_e)});
      @(posedge clk);
      wclr = (w && s == 4'd13) ? d[6:0] : 7'h00;
      m_f = (m_f & ~(wclr | s_clr)) | s_set;
      if (w && s == 4'd14) m_e = d[7] ? (m_e | d[6:0]) : (m_e & ~d[6:0]);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 0, 0, 13, 0, "R1");
      cyc(0, 0, 0, 14, 0, "R1");
      cyc(7'h41, 0, 0, 13, 0, "R2");       // set with enables off
      cyc(0, 0, 0, 13, 0, "R2");           // expect 0x41, irq 0
      cyc(7'h40, 0, 0, 13, 0, "R11");      // timer one source
      cyc(7'h20, 0, 0, 13, 0, "R11");      // timer two source
      cyc(0, 0, 0, 13, 0, "R11");          // expect 0x61
      cyc(0, 0, 1, 14, 8'hC0, "R7");       // enable bit 6
      cyc(0, 0, 0, 14, 0, "R8");           // expect 0xC0
      cyc(0, 0, 0, 13, 0, "R9");           // expect 0xE1, irq 1
      cyc(0, 0, 1, 14, 8'h40, "R6");       // disable bit 6
      cyc(0, 0, 0, 13, 0, "R9");           // summary drops
      cyc(0, 0, 1, 14, 8'h81, "R7");       // enable bit 0
      cyc(0, 0, 1, 13, 8'hC0, "R3");       // clear bit 6, bit 7 ignored
      cyc(0, 0, 0, 13, 0, "R3");           // expect 0xA1
      cyc(0, 7'h01, 0, 13, 0, "R4");       // side-effect clear bit 0
      cyc(0, 0, 0, 13, 0, "R4");           // expect 0x20
      cyc(7'h01, 0, 1, 13, 8'h01, "R5");   // set vs write clear
      cyc(0, 0, 0, 13, 0, "R5");
      cyc(7'h01, 7'h01, 0, 13, 0, "R5");   // set vs side-effect clear
      cyc(0, 0, 0, 13, 0, "R5");
      cyc(7'h02, 7'h02, 1, 13, 8'h02, "R5");
      cyc(0, 0, 0, 13, 0, "R5");
      cyc(0, 0, 1, 3, 8'hFF, "R12");       // unused offset write
      cyc(0, 0, 1, 15, 8'h7F, "R12");
      cyc(0, 0, 0, 13, 0, "R12");
      cyc(0, 0, 0, 14, 0, "R12");
      cyc(0, 0, 0, 7, 0, "R12");
      begin
         logic [31:0] x = 32'h1234_5678;
         for (int n = 0; n < 400; n++) begin
            logic [3:0] s;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            s = (x[2:0] < 3) ? 4'd13 : (x[2:0] < 6) ? 4'd14 : x[11:8];
            cyc(x[14:8] & x[22:16], x[21:15] & x[29:23], x[30], s, x[31:24], "R9");
         end
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule